// File: doc/BRIEF.md
# Framebuffer Control and Vertical-Blank Interrupt Register Window

This block is the control side of a simple framebuffer controller. It decodes a 32-byte, byte-addressed register window and holds a control byte, a status byte and a bank of general storage bytes. The status byte combines fixed board-identity bits with a live interrupt-pending flag. The palette part of the window, pixel fetch and video timing are outside this block. The bottom sixteen offsets are reserved for a palette port elsewhere and read as zero here.

A video timing generator pulses `vsync_evt` once per frame. When the interrupt-enable bit of the control byte is set, the pulse latches a pending flag and drives `irq` high. `irq` is a level signal. Software acknowledges it by writing anything to the status offset. Reads return data one cycle after the request, together with a one-cycle valid strobe.

Top module: `fbc_regwin`

## Requirements
- R1: After synchronous reset, `irq` is 0, the control byte and every storage byte read 0, and status reads 0x61.
- R2: Offset 0x10 is the control byte. All 8 bits are written by a write there and returned by a read there.
- R3: A `vsync_evt` pulse sets the pending flag when control bit 7 is 1 at that edge. `irq` is 1 from the following cycle.
- R4: A `vsync_evt` pulse has no effect when control bit 7 is 0. `irq` stays 0 and status still reads 0x61.
- R5: A read of offset 0x11 returns 0x61 ORed with the pending flag in bit 7, so it returns 0xE1 while pending.
- R6: Any write to offset 0x11 clears the pending flag and `irq` from the next cycle. The written data is ignored, and it does not change the identity bits or the control byte.
- R7: When a vsync pulse that would set pending and a status write fall in the same cycle, pending ends up set.
- R8: Offsets 0x12 to 0x1F are 14 independent read/write storage bytes with no side effects.
- R9: Offsets 0x00 to 0x0F read as 0. Writes there change no control, status or storage state.
- R10: `rd_vld` is 1 exactly in the cycle after a read request, and `rdata` carries that read's value in the same cycle.
- R11: `irq` rises only after a vsync pulse. Once set, it stays 1 through further vsync pulses until a status write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset within the window |
| acc_wdata | input | 8 | Write data |
| vsync_evt | input | 1 | One-cycle frame event pulse |
| rdata | output | 8 | Read data, valid with `rd_vld` |
| rd_vld | output | 1 | Read data strobe |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The properties assume that `vsync_evt` and every access request are sampled only at rising edges after reset. They also assume that `acc_addr` holds at most one request per cycle. The bench drives all inputs on falling edges. It starts and releases reset before any traffic, and it holds each request for exactly one cycle. Vsync pulses are one cycle wide, and in the coincidence case a vsync pulse is placed in the same cycle as a status write on purpose. Read expectations are queued when a request is issued and matched against each `rd_vld` strobe.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 8;
    localparam int WIN_BYTES   = 1 << ADDR_W;
    localparam int CTRL_OFF    = 16;
    localparam int STAT_OFF    = CTRL_OFF + 1;
    localparam int STORE_FIRST = CTRL_OFF + 2;
    localparam int STORE_CNT   = WIN_BYTES - STORE_FIRST;
    localparam int STORE_IDX_W = $clog2(STORE_CNT);
    localparam int IRQ_EN_BIT  = 7;
    localparam int PEND_BIT    = 7;
    localparam logic [DATA_W-1:0] STAT_ID = 8'h61;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_STAT,
        TGT_STORE
    } tgt_e;

    typedef struct packed {
        tgt_e                   tgt;
        logic [STORE_IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] rel;
        rel   = a - ADDR_W'(STORE_FIRST);
        d.tgt = TGT_NONE;
        d.idx = rel[STORE_IDX_W-1:0];
        if (a == ADDR_W'(CTRL_OFF))
            d.tgt = TGT_CTRL;
        else if (a == ADDR_W'(STAT_OFF))
            d.tgt = TGT_STAT;
        else if (a >= ADDR_W'(STORE_FIRST))
            d.tgt = TGT_STORE;
        return d;
    endfunction

endpackage

// File: rtl/fbc_decode.sv
module fbc_decode
    import fbc_pkg::*;
(
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output dec_t              dec,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              wr_store,
    output logic              rd_req
);
    always_comb begin
        dec      = decode_addr(acc_addr);
        wr_ctrl  = acc_en && acc_we && (dec.tgt == TGT_CTRL);
        wr_stat  = acc_en && acc_we && (dec.tgt == TGT_STAT);
        wr_store = acc_en && acc_we && (dec.tgt == TGT_STORE);
        rd_req   = acc_en && !acc_we;
    end
endmodule

// File: rtl/fbc_irq_ctl.sv
module fbc_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic vsync_evt,
    input  logic irq_en,
    input  logic ack,
    output logic pend
);
    logic set_now;

    assign set_now = vsync_evt && irq_en;

    // set has priority over the acknowledge
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set_now)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end
endmodule

// File: rtl/fbc_store_bank.sv
module fbc_store_bank #(
    parameter int COUNT = 14,
    parameter int IDX_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] mem [COUNT];

    for (genvar i = 0; i < COUNT; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr_en && (idx == IDX_W'(i)))
                mem[i] <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (idx == IDX_W'(i))
                rd_data = mem[i];
        end
    end
endmodule

// File: rtl/fbc_regwin.sv
module fbc_regwin
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              vsync_evt,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld,
    output logic              irq
);
    dec_t              dec;
    logic              wr_ctrl, wr_stat, wr_store, rd_req;
    logic [DATA_W-1:0] ctrl_q;
    logic              pend;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] rd_next;

    fbc_decode u_dec (
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .dec      (dec),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wr_store (wr_store),
        .rd_req   (rd_req)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= acc_wdata;
    end

    fbc_irq_ctl u_irq (
        .clk       (clk),
        .rst       (rst),
        .vsync_evt (vsync_evt),
        .irq_en    (ctrl_q[IRQ_EN_BIT]),
        .ack       (wr_stat),
        .pend      (pend)
    );

    fbc_store_bank #(
        .COUNT (STORE_CNT),
        .IDX_W (STORE_IDX_W),
        .DW    (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_store),
        .idx     (dec.idx),
        .wdata   (acc_wdata),
        .rd_data (store_rd)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_CTRL:  rd_next = ctrl_q;
            TGT_STAT:  rd_next = STAT_ID | (DATA_W'(pend) << PEND_BIT);
            TGT_STORE: rd_next = store_rd;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_req;
            rdata  <= rd_req ? rd_next : '0;
        end
    end

    assign irq = pend;
endmodule

// File: rtl/fbc_regwin_chk.sv
module fbc_regwin_chk
    import fbc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_en,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              vsync_evt,
    input logic              irq_en,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_vld,
    input logic              irq
);
    logic stat_wr;
    assign stat_wr = acc_en && acc_we && (acc_addr == ADDR_W'(STAT_OFF));

    assert_irq_set_R3: assert property (@(posedge clk) disable iff (rst)
        (vsync_evt && irq_en) |=> irq);

    assert_irq_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !(vsync_evt && irq_en)) |=> !irq);

    assert_irq_only_vsync_R11: assert property (@(posedge clk) disable iff (rst)
        (!irq && !vsync_evt) |=> !irq);

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq);

    assert_rd_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we) |=> rd_vld);

    assert_no_spurious_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && !acc_we) |=> !rd_vld);

    assert_stat_id_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we && acc_addr == ADDR_W'(STAT_OFF))
        |=> (rdata[6:0] == STAT_ID[6:0]));

    assert_low_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we && acc_addr < ADDR_W'(CTRL_OFF)) |=> (rdata == '0));
endmodule

bind fbc_regwin fbc_regwin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .vsync_evt (vsync_evt),
    .irq_en    (ctrl_q[7]),
    .rdata     (rdata),
    .rd_vld    (rd_vld),
    .irq       (irq)
);

// File: tb/fbc_regwin_bench.sv
module fbc_regwin_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_en = 1'b0, acc_we = 1'b0, vsync_evt = 1'b0;
    logic [4:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rdata;
    logic       rd_vld, irq;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    fbc_regwin u_fbc_regwin (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .vsync_evt(vsync_evt),
        .rdata(rdata), .rd_vld(rd_vld), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: match every read strobe against the queued expectation
    always @(negedge clk) begin
        if (!rst && rd_vld) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 actual=unexpected strobe expected=none");
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    task automatic access(input logic we, input logic [4:0] a, input logic [7:0] d,
                          input logic vs);
        @(negedge clk);
        acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d; vsync_evt = vs;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0; vsync_evt = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        access(1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(1'b0, a, 8'h00, 1'b0);
    endtask

    task automatic vsync_pulse();
        @(negedge clk);
        vsync_evt = 1'b1;
        @(negedge clk);
        vsync_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL R10 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(5'h10, 8'h00, "R1 ctrl");
        rd(5'h11, 8'h61, "R1 status");
        rd(5'h12, 8'h00, "R1 store first");
        rd(5'h1F, 8'h00, "R1 store last");
        // R2 control byte
        wr(5'h10, 8'hA5);
        rd(5'h10, 8'hA5, "R2 ctrl A5");
        wr(5'h10, 8'h5A);
        rd(5'h10, 8'h5A, "R2 ctrl 5A");
        // R4 vsync ignored while disabled
        vsync_pulse();
        check("R4 irq", {7'd0, irq}, 8'h00);
        rd(5'h11, 8'h61, "R4 status");
        // R3 / R5 / R11
        wr(5'h10, 8'h80);
        vsync_pulse();
        check("R3 irq", {7'd0, irq}, 8'h01);
        rd(5'h11, 8'hE1, "R5 status pending");
        vsync_pulse();
        check("R11 irq held", {7'd0, irq}, 8'h01);
        // R6 acknowledge
        wr(5'h11, 8'h00);
        check("R6 irq cleared", {7'd0, irq}, 8'h00);
        rd(5'h11, 8'h61, "R6 status");
        rd(5'h10, 8'h80, "R6 ctrl kept");
        wr(5'h11, 8'hFF);
        check("R6 idle write", {7'd0, irq}, 8'h00);
        rd(5'h11, 8'h61, "R6 data ignored");
        // R7 coincidence
        access(1'b1, 5'h11, 8'h00, 1'b1);
        check("R7 set wins", {7'd0, irq}, 8'h01);
        rd(5'h11, 8'hE1, "R7 status");
        wr(5'h11, 8'h00);
        check("R7 cleared after", {7'd0, irq}, 8'h00);
        // R8 storage
        for (int i = 0; i < 14; i++) wr(5'(18 + i), 8'(i * 17 + 3));
        for (int i = 0; i < 14; i++) rd(5'(18 + i), 8'(i * 17 + 3), "R8 store");
        // R9 low window
        wr(5'h00, 8'hFF);
        wr(5'h0F, 8'h77);
        wr(5'h02, 8'h11);
        rd(5'h00, 8'h00, "R9 low 00");
        rd(5'h0F, 8'h00, "R9 low 0F");
        rd(5'h02, 8'h00, "R9 low 02");
        rd(5'h10, 8'h80, "R9 ctrl intact");
        rd(5'h11, 8'h61, "R9 status intact");
        rd(5'h12, 8'h03, "R9 store intact");
        rd(5'h13, 8'h14, "R9 store intact 2");
        // R4 after disabling again
        wr(5'h10, 8'h7F);
        vsync_pulse();
        check("R4 disabled again", {7'd0, irq}, 8'h00);
        // R1 reset deasserts irq mid-run
        wr(5'h10, 8'h80);
        vsync_pulse();
        check("R3 before reset", {7'd0, irq}, 8'h01);
        do_reset();
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(5'h10, 8'h00, "R1 ctrl after reset");
        rd(5'h12, 8'h00, "R1 store after reset");
        rd(5'h11, 8'h61, "R1 status after reset");
        repeat (3) @(negedge clk);
        check("R10 queue drained", 8'(exp_q.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule